// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block sits behind an Ethernet receive MAC and decides, for every incoming frame, whether the frame is kept or dropped. It bases the decision only on the frame's 48-bit destination address. The address arrives with a one-cycle valid strobe. One clock later the block presents a registered accept flag and a 2-bit reason code that tells downstream logic which rule decided.

Four control bits set the behaviour, and they are layered. The promiscuous bit overrides everything. Below it, unicast and broadcast frames follow fixed rules. Multicast frames pass through three more layers:
- the filter-enable bit,
- then the multicast-enable bit,
- then the slot-select bit, which names which of two programmed group addresses must match.

Every 48-bit address (the local unicast address and both group addresses) is written as an upper 24-bit half and a lower 24-bit half on separate inputs.

Top module: `mac_rx_filter`

## Requirements
- R1: While reset is high, and on the first clock after it is released with no strobe, `dec_valid` and `dec_accept` are 0 and `dec_reason` is 2'b00.
- R2: `dec_valid` is high exactly in the cycle after a cycle with `rx_valid` high. `dec_accept` and `dec_reason` change only in response to a strobe and otherwise hold their last values.
- R3: With `cfg_promisc`=1 every frame is accepted with reason 2'b00, whatever its address and whatever the other control bits are.
- R4: With `cfg_promisc`=0, a unicast frame is accepted only when its address equals `{cfg_local_hi, cfg_local_lo}`. Unicast frames report reason 2'b01, whether accepted or dropped.
- R5: With `cfg_promisc`=0, the all-ones address is accepted with reason 2'b10 regardless of the multicast control bits.
- R6: An address is multicast when bit 40 (the least significant bit of the first octet, which is carried in bits 47:40) is 1 and the address is not all-ones. It is unicast when bit 40 is 0, even if other bits of the first octet are set. Multicast frames report reason 2'b11.
- R7: With `cfg_promisc`=0 and `cfg_filt_en`=0, every multicast frame is accepted.
- R8: With `cfg_filt_en`=1 and `cfg_mc_en`=0, every multicast frame is dropped.
- R9: With `cfg_filt_en`=1 and `cfg_mc_en`=1, a multicast frame is accepted only when it matches the slot named by `cfg_mc_sel` (0 selects slot 0, 1 selects slot 1). A frame that matches only the other slot is dropped.
- R10: Each programmed address is the upper half input in bits 47:24 joined to the lower half input in bits 23:0. A change to the lower half alone moves the address that matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_filt_en | input | 1 | Enable multicast filtering |
| cfg_mc_en | input | 1 | Allow multicast frames when filtering is enabled |
| cfg_mc_sel | input | 1 | Choose multicast slot 0 or 1 |
| cfg_mc0_hi | input | 24 | Slot 0 address, bits 47:24 |
| cfg_mc0_lo | input | 24 | Slot 0 address, bits 23:0 |
| cfg_mc1_hi | input | 24 | Slot 1 address, bits 47:24 |
| cfg_mc1_lo | input | 24 | Slot 1 address, bits 23:0 |
| cfg_local_hi | input | 24 | Local unicast address, bits 47:24 |
| cfg_local_lo | input | 24 | Local unicast address, bits 23:0 |
| rx_dst | input | 48 | Destination address of the received frame |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_dst` |
| dec_valid | output | 1 | Decision strobe, one clock after `rx_valid` |
| dec_accept | output | 1 | 1 = keep the frame, 0 = drop it |
| dec_reason | output | 2 | 00 promiscuous, 01 unicast, 10 broadcast, 11 multicast |

## Verification
The bench builds the block with its default 48-bit address width. With that width the halves are 24 bits each, and the group bit lands on bit 40.

These values let the tests do four things:
- Hit the boundary between the upper and lower halves by editing only a lower half.
- Separate the group bit from its neighbour in the first octet with a locally administered unicast address.
- Compare the all-ones broadcast against ordinary group addresses.
- Step the select bit between two real slots, so that a frame matching the wrong slot is seen to be dropped.

// File: rtl/mcf_pkg.sv
`timescale 1ns/1ps
package mcf_pkg;

    localparam int DEF_ADDR_W = 48;
    localparam int NUM_SLOTS  = 2;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);

    typedef enum logic [1:0] {
        RSN_PROMISC = 2'b00,
        RSN_UNICAST = 2'b01,
        RSN_BCAST   = 2'b10,
        RSN_MCAST   = 2'b11
    } reason_e;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_GROUP = 2'd2
    } frame_cls_e;

    typedef struct packed {
        logic    accept;
        reason_e reason;
    } verdict_t;

    typedef struct packed {
        logic promisc;
        logic filt_en;
        logic mc_en;
        logic mc_sel;
    } filt_ctrl_t;

    // Bit index of the group bit: LSB of the first transmitted octet.
    function automatic int group_bit_pos(input int addr_w);
        return addr_w - 8;
    endfunction

endpackage

// File: rtl/mcf_classify.sv
`timescale 1ns/1ps
module mcf_classify
    import mcf_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] dst,
    output frame_cls_e        cls
);
    localparam int GRP_BIT = group_bit_pos(ADDR_W);

    logic all_ones;
    logic grp;

    assign all_ones = &dst;
    assign grp      = dst[GRP_BIT];

    // Broadcast takes precedence over group classification.
    always_comb begin
        if (all_ones)
            cls = CLS_BCAST;
        else if (grp)
            cls = CLS_GROUP;
        else
            cls = CLS_UNI;
    end
endmodule

// File: rtl/mcf_addr_match.sv
`timescale 1ns/1ps
module mcf_addr_match
    import mcf_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic [ADDR_W-1:0]                 dst,
    input  logic [NUM_SLOTS-1:0][HALF_W-1:0]  slot_hi,
    input  logic [NUM_SLOTS-1:0][HALF_W-1:0]  slot_lo,
    input  logic [HALF_W-1:0]                 local_hi,
    input  logic [HALF_W-1:0]                 local_lo,
    output logic [NUM_SLOTS-1:0]              slot_hit,
    output logic                              local_hit
);
    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
            logic hi_eq;
            logic lo_eq;
            assign hi_eq       = (dst[ADDR_W-1:HALF_W] == slot_hi[g]);
            assign lo_eq       = (dst[HALF_W-1:0]      == slot_lo[g]);
            assign slot_hit[g] = hi_eq & lo_eq;
        end
    endgenerate

    assign local_hit = (dst[ADDR_W-1:HALF_W] == local_hi) &&
                       (dst[HALF_W-1:0]      == local_lo);
endmodule

// File: rtl/mcf_decide.sv
`timescale 1ns/1ps
module mcf_decide
    import mcf_pkg::*;
(
    input  filt_ctrl_t           ctrl,
    input  frame_cls_e           cls,
    input  logic [NUM_SLOTS-1:0] slot_hit,
    input  logic                 local_hit,
    output verdict_t             verdict
);
    logic sel_hit;

    assign sel_hit = slot_hit[SLOT_IDX_W'(ctrl.mc_sel)];

    always_comb begin
        verdict = '{accept: 1'b0, reason: RSN_PROMISC};
        if (ctrl.promisc) begin
            verdict.accept = 1'b1;
            verdict.reason = RSN_PROMISC;
        end else begin
            unique case (cls)
                CLS_BCAST: begin
                    verdict.accept = 1'b1;
                    verdict.reason = RSN_BCAST;
                end
                CLS_GROUP: begin
                    verdict.reason = RSN_MCAST;
                    if (!ctrl.filt_en)
                        verdict.accept = 1'b1;
                    else if (!ctrl.mc_en)
                        verdict.accept = 1'b0;
                    else
                        verdict.accept = sel_hit;
                end
                default: begin
                    verdict.reason = RSN_UNICAST;
                    verdict.accept = local_hit;
                end
            endcase
        end
    end
endmodule

// File: rtl/mac_rx_filter.sv
`timescale 1ns/1ps
module mac_rx_filter
    import mcf_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_promisc,
    input  logic              cfg_filt_en,
    input  logic              cfg_mc_en,
    input  logic              cfg_mc_sel,
    input  logic [HALF_W-1:0] cfg_mc0_hi,
    input  logic [HALF_W-1:0] cfg_mc0_lo,
    input  logic [HALF_W-1:0] cfg_mc1_hi,
    input  logic [HALF_W-1:0] cfg_mc1_lo,
    input  logic [HALF_W-1:0] cfg_local_hi,
    input  logic [HALF_W-1:0] cfg_local_lo,
    input  logic [ADDR_W-1:0] rx_dst,
    input  logic              rx_valid,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [1:0]        dec_reason
);
    filt_ctrl_t                        ctrl;
    frame_cls_e                        cls;
    logic [NUM_SLOTS-1:0][HALF_W-1:0]  slot_hi;
    logic [NUM_SLOTS-1:0][HALF_W-1:0]  slot_lo;
    logic [NUM_SLOTS-1:0]              slot_hit;
    logic                              local_hit;
    verdict_t                          verdict_d;
    verdict_t                          verdict_q;
    logic                              valid_q;

    assign ctrl = '{promisc: cfg_promisc, filt_en: cfg_filt_en,
                    mc_en: cfg_mc_en, mc_sel: cfg_mc_sel};

    assign slot_hi[0] = cfg_mc0_hi;
    assign slot_lo[0] = cfg_mc0_lo;
    assign slot_hi[1] = cfg_mc1_hi;
    assign slot_lo[1] = cfg_mc1_lo;

    mcf_classify #(.ADDR_W(ADDR_W)) u_classify (
        .dst (rx_dst),
        .cls (cls)
    );

    mcf_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .dst       (rx_dst),
        .slot_hi   (slot_hi),
        .slot_lo   (slot_lo),
        .local_hi  (cfg_local_hi),
        .local_lo  (cfg_local_lo),
        .slot_hit  (slot_hit),
        .local_hit (local_hit)
    );

    mcf_decide u_decide (
        .ctrl      (ctrl),
        .cls       (cls),
        .slot_hit  (slot_hit),
        .local_hit (local_hit),
        .verdict   (verdict_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '{accept: 1'b0, reason: RSN_PROMISC};
        end else begin
            valid_q <= rx_valid;
            if (rx_valid)
                verdict_q <= verdict_d;
        end
    end

    assign dec_valid  = valid_q;
    assign dec_accept = verdict_q.accept;
    assign dec_reason = verdict_q.reason;
endmodule

// File: rtl/mac_rx_filter_chk.sv
`timescale 1ns/1ps
module mac_rx_filter_chk #(
    parameter int ADDR_W = 48,
    localparam int HALF_W = ADDR_W / 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_promisc,
    input logic              cfg_filt_en,
    input logic              cfg_mc_en,
    input logic              cfg_mc_sel,
    input logic [HALF_W-1:0] cfg_mc0_hi,
    input logic [HALF_W-1:0] cfg_mc0_lo,
    input logic [HALF_W-1:0] cfg_mc1_hi,
    input logic [HALF_W-1:0] cfg_mc1_lo,
    input logic [HALF_W-1:0] cfg_local_hi,
    input logic [HALF_W-1:0] cfg_local_lo,
    input logic [ADDR_W-1:0] rx_dst,
    input logic              rx_valid,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [1:0]        dec_reason
);
    localparam int GB = ADDR_W - 8;

    logic is_bc;
    logic is_grp;
    assign is_bc  = &rx_dst;
    assign is_grp = rx_dst[GB] && !is_bc;

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> !dec_valid && !dec_accept && dec_reason == 2'b00);

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst) rx_valid |=> dec_valid);

    // R2
    no_strobe_chk: assert property (@(posedge clk) disable iff (rst) !rx_valid |=> !dec_valid && $stable(dec_accept) && $stable(dec_reason));

    // R3
    promisc_pass_chk: assert property (@(posedge clk) disable iff (rst) rx_valid && cfg_promisc |=> dec_accept && dec_reason == 2'b00);

    // R4
    uni_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !cfg_promisc && !rx_dst[GB] && rx_dst != {cfg_local_hi, cfg_local_lo}
        |=> !dec_accept && dec_reason == 2'b01);

    // R5
    bcast_pass_chk: assert property (@(posedge clk) disable iff (rst) rx_valid && !cfg_promisc && is_bc |=> dec_accept && dec_reason == 2'b10);

    // R7
    filt_off_chk: assert property (@(posedge clk) disable iff (rst) rx_valid && !cfg_promisc && is_grp && !cfg_filt_en |=> dec_accept && dec_reason == 2'b11);

    // R8
    mc_block_chk: assert property (@(posedge clk) disable iff (rst) rx_valid && !cfg_promisc && is_grp && cfg_filt_en && !cfg_mc_en |=> !dec_accept && dec_reason == 2'b11);
endmodule

bind mac_rx_filter mac_rx_filter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mac_rx_filter_tb.sv
`timescale 1ns/1ps
module mac_rx_filter_tb;
    localparam int AW = 48;
    localparam int HW = AW / 2;

    localparam logic [AW-1:0] LOCAL_A  = 48'h02_11_22_33_44_55;
    localparam logic [AW-1:0] OTHER_U  = 48'h0A_00_00_00_00_01;
    localparam logic [AW-1:0] ADMIN_U  = 48'h02_00_00_00_00_07;
    localparam logic [AW-1:0] MC0_A    = 48'h01_00_5E_00_01_81;
    localparam logic [AW-1:0] MC1_A    = 48'h01_1B_19_00_00_00;
    localparam logic [AW-1:0] OTHER_M  = 48'h03_00_00_00_00_01;
    localparam logic [AW-1:0] BCAST_A  = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_promisc, cfg_filt_en, cfg_mc_en, cfg_mc_sel;
    logic [HW-1:0] cfg_mc0_hi, cfg_mc0_lo, cfg_mc1_hi, cfg_mc1_lo;
    logic [HW-1:0] cfg_local_hi, cfg_local_lo;
    logic [AW-1:0] rx_dst;
    logic          rx_valid;
    logic          dec_valid, dec_accept;
    logic [1:0]    dec_reason;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mac_rx_filter #(.ADDR_W(AW)) u_dut (.*);

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic p, input logic f, input logic m, input logic s);
        cfg_promisc = p; cfg_filt_en = f; cfg_mc_en = m; cfg_mc_sel = s;
    endtask

    // Drive one strobe, sample after the registering edge.
    task automatic send(input string req, input logic [AW-1:0] dst,
                        input logic exp_acc, input logic [1:0] exp_rsn);
        @(negedge clk);
        rx_dst   = dst;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_dst   = '0;
        check_eq("R2", "dec_valid", 32'(dec_valid), 32'd1);
        check_eq(req, "dec_accept", 32'(dec_accept), 32'(exp_acc));
        check_eq(req, "dec_reason", 32'(dec_reason), 32'(exp_rsn));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "dec_valid in reset", 32'(dec_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "dec_valid", 32'(dec_valid), 32'd0);
        check_eq("R1", "dec_accept", 32'(dec_accept), 32'd0);
        check_eq("R1", "dec_reason", 32'(dec_reason), 32'd0);
    endtask

    task automatic t_unicast();
        set_mode(0, 1, 0, 0);
        send("R4", LOCAL_A, 1'b1, 2'b01);
        send("R4", OTHER_U, 1'b0, 2'b01);
        // r6_: bit 41 set but group bit clear -> unicast
        send("R6", ADMIN_U, 1'b0, 2'b01);
    endtask

    task automatic t_hold();
        set_mode(0, 0, 0, 0);
        send("R2", LOCAL_A, 1'b1, 2'b01);
        // Garbage on the address bus with no strobe must not move the outputs.
        rx_dst = OTHER_U;
        repeat (2) @(negedge clk);
        check_eq("R2", "dec_valid idle", 32'(dec_valid), 32'd0);
        check_eq("R2", "dec_accept held", 32'(dec_accept), 32'd1);
        check_eq("R2", "dec_reason held", 32'(dec_reason), 32'd1);
        rx_dst = '0;
    endtask

    task automatic t_bcast();
        set_mode(0, 1, 0, 0);
        send("R5", BCAST_A, 1'b1, 2'b10);
        set_mode(0, 1, 1, 1);
        send("R5", BCAST_A, 1'b1, 2'b10);
    endtask

    task automatic t_promisc();
        set_mode(1, 1, 0, 0);
        send("R3", OTHER_U, 1'b1, 2'b00);
        send("R3", MC0_A, 1'b1, 2'b00);
        send("R3", BCAST_A, 1'b1, 2'b00);
    endtask

    task automatic t_filter_off();
        set_mode(0, 0, 0, 0);
        send("R7", OTHER_M, 1'b1, 2'b11);
        send("R6", MC1_A, 1'b1, 2'b11);
    endtask

    task automatic t_mc_block();
        set_mode(0, 1, 0, 0);
        send("R8", MC0_A, 1'b0, 2'b11);
        set_mode(0, 1, 0, 1);
        send("R8", MC1_A, 1'b0, 2'b11);
    endtask

    task automatic t_mc_select();
        set_mode(0, 1, 1, 0);
        send("R9", MC0_A, 1'b1, 2'b11);
        send("R9", MC1_A, 1'b0, 2'b11);
        send("R9", OTHER_M, 1'b0, 2'b11);
        set_mode(0, 1, 1, 1);
        send("R9", MC1_A, 1'b1, 2'b11);
        send("R9", MC0_A, 1'b0, 2'b11);
    endtask

    task automatic t_halves();
        set_mode(0, 1, 1, 0);
        cfg_mc0_lo = 24'h000182;
        send("R10", MC0_A, 1'b0, 2'b11);
        send("R10", 48'h01_00_5E_00_01_82, 1'b1, 2'b11);
        cfg_local_lo = 24'h334456;
        set_mode(0, 0, 0, 0);
        send("R10", LOCAL_A, 1'b0, 2'b01);
        send("R10", 48'h02_11_22_33_44_56, 1'b1, 2'b01);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        set_mode(0, 0, 0, 0);
        cfg_mc0_hi   = MC0_A[AW-1:HW];
        cfg_mc0_lo   = MC0_A[HW-1:0];
        cfg_mc1_hi   = MC1_A[AW-1:HW];
        cfg_mc1_lo   = MC1_A[HW-1:0];
        cfg_local_hi = LOCAL_A[AW-1:HW];
        cfg_local_lo = LOCAL_A[HW-1:0];
        rx_dst       = '0;
        rx_valid     = 1'b0;
        t_reset();
        t_unicast();
        t_hold();
        t_bcast();
        t_promisc();
        t_filter_off();
        t_mc_block();
        t_mc_select();
        t_halves();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule